// File: doc/BRIEF.md
# Sub-word Load/Store Data Memory

This block is a data memory organised as 64-bit words that a load/store path reaches with byte addresses. A request carries a byte address, an access size of 1, 2, 4 or 8 bytes, a 64-bit store value and separate load and store strobes. The address splits into a word index, which is the address shifted right by three and reduced to the memory depth, and a 3-bit byte offset inside that word. The lowest byte offset names the most significant byte lane of the word, so byte 0 lives in bits 63:56.

A store narrower than the word reads the word that holds it, clears only the addressed lane, and merges in the store value cut down to the access size. The other bytes of the word keep their values. A load picks out the addressed lane, shifts it down to bit 0 and zero-extends it. Load results are registered and appear one cycle after the request. An access whose offset is not a multiple of its size is refused. It raises an error flag, writes nothing and returns zero.

Top module: `subword_mem`

## Requirements
- R1: After reset every word reads as zero, and `ld_data` and `misalign` are zero.
- R2: The word index is `req_addr >> 3` taken modulo `DEPTH`, so two addresses that differ by a multiple of `DEPTH*8` reach the same word.
- R3: The size code `req_size` is 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes. Byte offset k (the low 3 address bits) maps to word bits [63-8k -: 8], so offset 0 is the most significant lane.
- R4: A store of 1, 2 or 4 bytes changes only the addressed lane and keeps every other byte of the word.
- R5: An 8-byte store at offset 0 replaces the whole word.
- R6: A load returns the addressed lane in the low bits of `ld_data` with all higher bits zero, with the first byte of the lane as the most significant byte of the result.
- R7: Only the low 8×size bits of `st_data` are stored; its higher bits affect no byte of memory.
- R8: A request whose offset is not a multiple of its size sets `misalign` in the next cycle, leaves memory unchanged and gives `ld_data` zero.
- R9: `ld_data` holds the result of a load issued in the previous cycle, and is zero in the cycle after a cycle without a legal load.
- R10: When load and store strobes are both set, the store is performed and the load returns the word's contents from before that store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| ld_en | input | 1 | Load strobe |
| st_en | input | 1 | Store strobe |
| st_data | input | 64 | Store value, right-aligned |
| ld_data | output | 64 | Zero-extended load result, one cycle after the request |
| misalign | output | 1 | Set one cycle after a misaligned request |

## Verification
The hardest case to reach from the ports is one where a narrow store's merge could disturb a neighbour byte. Such a fault shows only when that neighbour already holds a non-zero value and is later read with a size and offset that cover it. The stimulus therefore first fills words with full 8-byte stores. It then draws narrow stores with junk in the high bits of the store value and loads of every size, confined to a small address window that also aliases through the depth. That way most narrow stores land on words that already hold data and get read back in other shapes. Directed cases cover the most significant lane, a misaligned store followed by a full read, and a load and a store issued together.

// File: rtl/subword_mem_pkg.sv
package subword_mem_pkg;

    localparam int WORD_BITS  = 64;
    localparam int WORD_BYTES = WORD_BITS / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef logic [WORD_BITS-1:0] word_t;

    // Registered outputs of the top level.
    typedef struct packed {
        word_t ld_data;
        logic  misalign;
    } resp_t;

endpackage

// File: rtl/subword_lane.sv
// Lane geometry of one access: alignment, bit shift and unshifted mask.
module subword_lane
    import subword_mem_pkg::*;
(
    input  logic [1:0]       size_code,
    input  logic [OFF_W-1:0] byte_off,
    output logic             legal,
    output logic [5:0]       shift_bits,
    output word_t            lane_mask
);
    logic [3:0] nbytes;
    logic [3:0] lane_pos;

    always_comb begin
        nbytes   = 4'd1 << size_code;
        legal    = (byte_off & OFF_W'(nbytes - 4'd1)) == '0;
        // Offset 0 is the top lane: shift = (8 - bytes - offset) bytes.
        lane_pos = 4'd8 - nbytes - {1'b0, byte_off};
        shift_bits = {lane_pos[2:0], 3'b000};
    end

    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_mask
        assign lane_mask[8*b +: 8] = (4'(b) < nbytes) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/subword_merge.sv
// Read-modify-write merge of a lane-sized value into an existing word.
module subword_merge
    import subword_mem_pkg::*;
(
    input  word_t      old_word,
    input  word_t      new_val,
    input  word_t      lane_mask,
    input  logic [5:0] shift_bits,
    output word_t      merged
);
    word_t placed_mask;
    word_t placed_val;

    always_comb begin
        placed_mask = lane_mask << shift_bits;
        placed_val  = (new_val & lane_mask) << shift_bits;
        merged      = (old_word & ~placed_mask) | placed_val;
    end

endmodule

// File: rtl/subword_array.sv
// Word storage with reset-to-zero contents, one write port, async read.
module subword_array
    import subword_mem_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t mem_q [DEPTH];
    word_t mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[idx];

    // R8: a cycle without a write leaves the addressed word as it was.
    p_idle_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (mem_q[$past(idx)] == $past(rdata)));

endmodule

// File: rtl/subword_mem.sv
module subword_mem
    import subword_mem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              ld_en,
    input  logic              st_en,
    input  logic [63:0]       st_data,
    output logic [63:0]       ld_data,
    output logic              misalign
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0] word_idx;
    logic [OFF_W-1:0] byte_off;
    logic             legal;
    logic [5:0]       shift_bits;
    word_t            lane_mask;
    word_t            cur_word;
    word_t            merged;
    logic             wr_en;
    resp_t            resp_d, resp_q;

    assign word_idx = req_addr[OFF_W +: IDX_W];
    assign byte_off = req_addr[OFF_W-1:0];

    subword_lane u_lane (
        .size_code  (req_size),
        .byte_off   (byte_off),
        .legal      (legal),
        .shift_bits (shift_bits),
        .lane_mask  (lane_mask)
    );

    subword_merge u_merge (
        .old_word   (cur_word),
        .new_val    (st_data),
        .lane_mask  (lane_mask),
        .shift_bits (shift_bits),
        .merged     (merged)
    );

    assign wr_en = st_en && legal;

    subword_array #(.DEPTH(DEPTH)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .idx   (word_idx),
        .wdata (merged),
        .rdata (cur_word)
    );

    always_comb begin
        resp_d          = '0;
        resp_d.misalign = (ld_en || st_en) && !legal;
        if (ld_en && legal) begin
            resp_d.ld_data = (cur_word >> shift_bits) & lane_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign ld_data  = resp_q.ld_data;
    assign misalign = resp_q.misalign;

    // R8: a flagged request never returns data.
    p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (ld_data == '0));

    // R8: odd address with size above one byte is refused next cycle.
    p_odd_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ld_en || st_en) && req_addr[0] && (req_size != 2'd0)) |=> misalign);

    // R9: no load strobe gives zero data in the next cycle.
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> (ld_data == '0));

    // R4: a narrow legal store leaves bytes outside its lane untouched.
    p_keep_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (req_size != 2'd3)) |->
            (((merged ^ cur_word) & ~(lane_mask << shift_bits)) == '0));

    // R6: load data never reaches above the access width.
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && legal) |=> ((ld_data & ~$past(lane_mask)) == '0));

endmodule

// File: tb/subword_mem_tb_top.sv
`timescale 1ns/1ps
module subword_mem_tb_top;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              ld_en = 1'b0;
    logic              st_en = 1'b0;
    logic [63:0]       st_data = '0;
    logic [63:0]       ld_data;
    logic              misalign;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [63:0] model [DEPTH];

    always #2.5 clk = ~clk;

    subword_mem #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_addr (req_addr),
        .req_size (req_size),
        .ld_en    (ld_en),
        .st_en    (st_en),
        .st_data  (st_data),
        .ld_data  (ld_data),
        .misalign (misalign)
    );

    function automatic int size_bytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    function automatic bit is_aligned(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
        return (a % size_bytes(sz)) == 0;
    endfunction

    // Byte k of a word sits in bits [63-8k -: 8].
    function automatic logic [63:0] read_lane(input logic [63:0] w, input int off, input int n);
        logic [63:0] r = '0;
        for (int i = 0; i < n; i++) begin
            r = (r << 8) | 64'(w[63 - 8*(off+i) -: 8]);
        end
        return r;
    endfunction

    function automatic logic [63:0] write_lane(input logic [63:0] w, input int off,
                                               input int n, input logic [63:0] v);
        logic [63:0] r = w;
        for (int i = 0; i < n; i++) begin
            r[63 - 8*(off+i) -: 8] = v[8*(n-1-i) +: 8];
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, sample results one cycle later.
    task automatic op(input string tag, input bit ld, input bit st,
                      input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                      input logic [63:0] d);
        int idx = int'((a >> 3) % DEPTH);
        int off = int'(a[2:0]);
        bit ok = is_aligned(a, sz);
        logic [63:0] exp_data = '0;
        bit exp_err = (ld || st) && !ok;
        if (ld && ok) exp_data = read_lane(model[idx], off, size_bytes(sz));
        req_addr = a; req_size = sz; ld_en = ld; st_en = st; st_data = d;
        @(negedge clk);
        check({tag, " data"}, ld_data, exp_data);
        check({tag, " misalign"}, 64'(misalign), 64'(exp_err));
        if (st && ok) model[idx] = write_lane(model[idx], off, size_bytes(sz), d);
        ld_en = 1'b0; st_en = 1'b0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset outputs and contents.
        check("R1 ld_data after reset", ld_data, '0);
        check("R1 misalign after reset", 64'(misalign), '0);
        for (int i = 0; i < DEPTH; i++) op("R1 empty word", 1, 0, 16'(i*8), 2'd3, '0);

        // R3: offset 0 single byte lands in the top lane.
        op("R3 byte store off0", 0, 1, 16'h0000, 2'd0, 64'hAB);
        op("R3 full read", 1, 0, 16'h0000, 2'd3, '0);
        check("R3 top lane", model[0], 64'hAB00_0000_0000_0000);
        op("R3 byte store off7", 0, 1, 16'h0007, 2'd0, 64'hCD);
        op("R3 full read low lane", 1, 0, 16'h0000, 2'd3, '0);

        // R5: full replace.
        op("R5 full store", 0, 1, 16'h0008, 2'd3, 64'h0123_4567_89AB_CDEF);
        op("R5 full read", 1, 0, 16'h0008, 2'd3, '0);

        // R4/R7: narrow store with junk high bits keeps neighbours.
        op("R7 byte store junk", 0, 1, 16'h0009, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A);
        op("R4 neighbours kept", 1, 0, 16'h0008, 2'd3, '0);
        op("R7 half store junk", 0, 1, 16'h000C, 2'd1, 64'hDEAD_BEEF_0000_7777);
        op("R4 neighbours kept half", 1, 0, 16'h0008, 2'd3, '0);

        // R6: narrow loads zero-extend.
        op("R6 byte load", 1, 0, 16'h0009, 2'd0, '0);
        op("R6 half load", 1, 0, 16'h000E, 2'd1, '0);
        op("R6 word load", 1, 0, 16'h000C, 2'd2, '0);

        // R8: misaligned store changes nothing.
        op("R8 misaligned store", 0, 1, 16'h000A, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        op("R8 memory unchanged", 1, 0, 16'h0008, 2'd3, '0);
        op("R8 misaligned load", 1, 0, 16'h0003, 2'd1, '0);

        // R2: aliasing through the depth.
        op("R2 alias read", 1, 0, 16'(DEPTH*8 + 8), 2'd3, '0);
        op("R2 alias write", 0, 1, 16'(DEPTH*8*3), 2'd2, 64'h1122_3344);
        op("R2 alias readback", 1, 0, 16'h0000, 2'd3, '0);

        // R10: load and store together return old contents.
        op("R10 ld+st", 1, 1, 16'h0008, 2'd3, 64'h5555_AAAA_5555_AAAA);
        op("R10 after", 1, 0, 16'h0008, 2'd3, '0);

        // R9: idle cycle gives zero data.
        op("R9 load", 1, 0, 16'h0008, 2'd3, '0);
        op("R9 idle", 0, 0, 16'h0008, 2'd3, '0);

        // Random: fill, then mixed narrow traffic in a small aliased window.
        for (int i = 0; i < 8; i++)
            op("R5 random fill", 0, 1, 16'(i*8), 2'd3, {$urandom, $urandom});
        for (int n = 0; n < 3000; n++) begin
            logic [ADDR_W-1:0] a = 16'($urandom_range(0, 8*DEPTH*2 - 1));
            logic [1:0] sz = 2'($urandom_range(0, 3));
            int kind = $urandom_range(0, 9);
            if (kind < 8) a = a & ~16'(size_bytes(sz) - 1);
            op("R4 R6 R8 random", kind[0] || kind == 8, !kind[0] || kind == 9,
               a, sz, {$urandom, $urandom});
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule